// File: doc/BRIEF.md
# ADC Channel Auto-Scan Sequencer

This block chooses which of the eight analog inputs feeds the converter in each conversion cycle. A cycle is a fixed run of serial clocks, 16 by default, counted by the block itself from reset. At the last clock of every cycle the block samples the 16-bit control word assembled by the serial front end during that cycle. It drives the resulting channel onto the multiplexer select for the whole of the following cycle. A one-clock strobe marks the first clock of every cycle in which a fresh select has been applied.

Bit 10 of the control word chooses between two behaviours. In manual mode the three bits 9..7 name the channel directly. In scan mode bits 9..8 pick one of four fixed orders, and the block moves one step along that order per cycle, wrapping at its end. Bit 7 is then a restart request that sends the scan back to the first entry of the order.

The controller has two states: MANUAL (the reset state) and SCAN. At each cycle boundary it takes exactly one named transition. HOLD_MANUAL stays in MANUAL and loads the manual channel. ENTER_SCAN goes from MANUAL to SCAN at the first entry of the order. STEP stays in SCAN and advances one entry. RESTART stays in SCAN and returns to the first entry, either because bit 7 is set or because the order field changed. LEAVE_SCAN goes from SCAN back to MANUAL and loads the manual channel. Between boundaries the controller makes the WAIT move, which changes nothing.

Top module: `adc_scan_seq`

## Requirements
- R1: While reset is high and on the first clock after it, mux_sel is 0 and sel_valid is 0. The controller is in manual mode.
- R2: The control word is sampled on every 16th rising clock edge after reset is released. sel_valid is high for exactly the one clock that follows each of those edges and low at all other times.
- R3: When bit 10 of the sampled word is 0, mux_sel becomes the binary value of bits 9..7 (000 is channel 0, 111 is channel 7). All other bits of the word have no effect on it.
- R4: In scan mode with bits 9..8 = 00, successive cycles select 0,1,2,3,4,5,6,7.
- R5: In scan mode with bits 9..8 = 01, successive cycles select 1,3,5,7.
- R6: In scan mode with bits 9..8 = 10, successive cycles select 0,2,4,6.
- R7: In scan mode with bits 9..8 = 11, successive cycles select 7,6,5,4,3,2,1,0.
- R8: After the last entry of an order, the next cycle selects the first entry of the same order.
- R9: In scan mode, bit 7 = 1 makes that cycle select the first entry of the chosen order. Bit 7 = 0 lets the scan advance normally.
- R10: If the order field changes while scan mode stays on, the scan restarts at the first entry of the new order.
- R11: A cycle that enters scan mode from manual mode selects the first entry of the chosen order.
- R12: mux_sel changes only on the clock edge that raises sel_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock. All state advances on its rising edge. |
| rst | input | 1 | Synchronous reset, active high. |
| cfg_word | input | 16 | Control word captured during the current cycle. It is sampled at the cycle's last clock. |
| mux_sel | output | 3 | Channel select for the analog multiplexer. |
| sel_valid | output | 1 | One-clock strobe at the start of each cycle, when a new select is applied. |

## Verification
The awkward case is the separation between a restart and a plain advance. Both keep the controller in scan mode, and a restart that lands on the entry a step would have reached looks identical at the ports. The stimulus therefore first runs an order a few steps away from its start. It then asserts the restart bit, or switches order, at a point where the expected first entry differs from the next entry of the old order. The descending order is also driven past its wrap, so that the channel-7 entry is reached both by wrapping and by restart.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    // Control word field positions (decoded by the serial front end's word)
    localparam int MODE_BIT = 10;
    localparam int MAN_HI   = 9;
    localparam int MAN_LO   = 7;
    localparam int ORD_HI   = 9;
    localparam int ORD_LO   = 8;
    localparam int RST_BIT  = 7;

    typedef enum logic [1:0] {
        ORD_ASC  = 2'b00,
        ORD_ODD  = 2'b01,
        ORD_EVEN = 2'b10,
        ORD_DESC = 2'b11
    } scan_order_e;

    typedef enum logic {
        ST_MANUAL = 1'b0,
        ST_SCAN   = 1'b1
    } seq_state_e;

    typedef enum logic [2:0] {
        MV_WAIT,
        MV_HOLD_MANUAL,
        MV_ENTER_SCAN,
        MV_STEP,
        MV_RESTART,
        MV_LEAVE_SCAN
    } seq_move_e;

    // Number of entries an order visits for a given channel count
    function automatic int order_len(scan_order_e o, int n);
        return (o == ORD_ODD || o == ORD_EVEN) ? n / 2 : n;
    endfunction

endpackage

// File: rtl/scan_cycle_timer.sv
module scan_cycle_timer #(
    parameter  int CYC_LEN = 16,
    localparam int CNT_W   = $clog2(CYC_LEN)
) (
    input  logic clk,
    input  logic rst,
    output logic boundary
);

    logic [CNT_W-1:0] cnt_q;

    assign boundary = (cnt_q == CNT_W'(CYC_LEN - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (boundary) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/scan_order_table.sv
module scan_order_table
    import adc_scan_pkg::*;
#(
    parameter  int NUM_CH = 8,
    localparam int CH_W   = $clog2(NUM_CH)
) (
    input  scan_order_e       order,
    input  logic [CH_W-1:0]   idx,
    output logic [CH_W-1:0]   chan
);

    localparam int N_ORD = 4;

    logic [CH_W-1:0] tbl [N_ORD][NUM_CH];

    for (genvar o = 0; o < N_ORD; o++) begin : g_ord
        for (genvar k = 0; k < NUM_CH; k++) begin : g_ent
            localparam int VAL = (o == 0) ? k :
                                 (o == 1) ? (2 * k + 1) % NUM_CH :
                                 (o == 2) ? (2 * k) % NUM_CH :
                                            NUM_CH - 1 - k;
            assign tbl[o][k] = CH_W'(VAL);
        end
    end

    assign chan = tbl[order][idx];

endmodule

// File: rtl/scan_ctrl_fsm.sv
module scan_ctrl_fsm
    import adc_scan_pkg::*;
#(
    parameter  int NUM_CH = 8,
    parameter  int CFG_W  = 16,
    localparam int CH_W   = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              boundary,
    input  logic [CFG_W-1:0]  cfg_word,
    output logic [CH_W-1:0]   mux_sel,
    output logic              sel_valid
);

    localparam logic [CFG_W-1:0] USED_MASK =
        CFG_W'((1 << (MODE_BIT + 1)) - (1 << MAN_LO));

    seq_state_e      state_q, state_d;
    scan_order_e     ord_q, ord_d;
    logic [CH_W-1:0] ptr_q, ptr_d;
    seq_move_e       move;

    logic            cfg_scan;
    logic            cfg_restart;
    scan_order_e     cfg_ord;
    logic [CH_W-1:0] cfg_man;
    logic            cfg_unused;
    logic            at_last;
    logic [CH_W-1:0] scan_chan;
    logic [CH_W-1:0] sel_d;

    assign cfg_scan    = cfg_word[MODE_BIT];
    assign cfg_restart = cfg_word[RST_BIT];
    assign cfg_ord     = scan_order_e'(cfg_word[ORD_HI:ORD_LO]);
    assign cfg_man     = CH_W'(cfg_word[MAN_HI:MAN_LO]);
    assign cfg_unused  = ^(cfg_word & ~USED_MASK);

    assign at_last = (int'(ptr_q) == order_len(ord_q, NUM_CH) - 1);

    scan_order_table #(.NUM_CH(NUM_CH)) u_table (
        .order (ord_d),
        .idx   (ptr_d),
        .chan  (scan_chan)
    );

    // Transition choice
    always_comb begin
        move = MV_WAIT;
        unique case (state_q)
            ST_MANUAL: begin
                if (!boundary)     move = MV_WAIT;
                else if (cfg_scan) move = MV_ENTER_SCAN;
                else               move = MV_HOLD_MANUAL;
            end
            ST_SCAN: begin
                if (!boundary)                              move = MV_WAIT;
                else if (!cfg_scan)                         move = MV_LEAVE_SCAN;
                else if (cfg_restart || (cfg_ord != ord_q)) move = MV_RESTART;
                else                                        move = MV_STEP;
            end
        endcase
    end

    // Next state, order and pointer per move
    always_comb begin
        state_d = state_q;
        ord_d   = ord_q;
        ptr_d   = ptr_q;
        sel_d   = mux_sel;
        unique case (move)
            MV_WAIT: begin
            end
            MV_HOLD_MANUAL, MV_LEAVE_SCAN: begin
                state_d = ST_MANUAL;
                ptr_d   = '0;
                sel_d   = cfg_man;
            end
            MV_ENTER_SCAN, MV_RESTART: begin
                state_d = ST_SCAN;
                ord_d   = cfg_ord;
                ptr_d   = '0;
                sel_d   = scan_chan;
            end
            MV_STEP: begin
                state_d = ST_SCAN;
                ptr_d   = at_last ? '0 : ptr_q + CH_W'(1);
                sel_d   = scan_chan;
            end
            default: begin
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_MANUAL;
            ord_q   <= ORD_ASC;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            ord_q   <= ord_d;
            ptr_q   <= ptr_d;
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            mux_sel   <= '0;
            sel_valid <= 1'b0;
        end else begin
            sel_valid <= (move != MV_WAIT);
            if (move != MV_WAIT) begin
                mux_sel <= sel_d;
            end
        end
    end

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
    parameter  int NUM_CH  = 8,
    parameter  int CYC_LEN = 16,
    parameter  int CFG_W   = 16,
    localparam int CH_W    = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CFG_W-1:0]  cfg_word,
    output logic [CH_W-1:0]   mux_sel,
    output logic              sel_valid
);

    logic boundary;

    scan_cycle_timer #(.CYC_LEN(CYC_LEN)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .boundary (boundary)
    );

    scan_ctrl_fsm #(.NUM_CH(NUM_CH), .CFG_W(CFG_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .boundary  (boundary),
        .cfg_word  (cfg_word),
        .mux_sel   (mux_sel),
        .sel_valid (sel_valid)
    );

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk
    import adc_scan_pkg::*;
#(
    parameter  int NUM_CH  = 8,
    parameter  int CYC_LEN = 16,
    parameter  int CFG_W   = 16,
    localparam int CH_W    = $clog2(NUM_CH)
) (
    input logic              clk,
    input logic              rst,
    input logic [CFG_W-1:0]  cfg_word,
    input logic [CH_W-1:0]   mux_sel,
    input logic              sel_valid
);

    // R2: the strobe never lasts two clocks
    p_single_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        sel_valid |=> !sel_valid);

    // R12: select holds between strobes
    p_hold_sel_r12: assert property (@(posedge clk) disable iff (rst)
        !sel_valid |-> $stable(mux_sel));

    // R3: manual channel follows the sampled word
    p_manual_r3: assert property (@(posedge clk) disable iff (rst)
        (sel_valid && !$past(cfg_word[MODE_BIT]))
        |-> (mux_sel == CH_W'($past(cfg_word[MAN_HI:MAN_LO]))));

    // R5: odd order only yields odd channels
    p_odd_r5: assert property (@(posedge clk) disable iff (rst)
        (sel_valid && $past(cfg_word[MODE_BIT]) &&
         ($past(cfg_word[ORD_HI:ORD_LO]) == 2'b01)) |-> mux_sel[0]);

    // R6: even order only yields even channels
    p_even_r6: assert property (@(posedge clk) disable iff (rst)
        (sel_valid && $past(cfg_word[MODE_BIT]) &&
         ($past(cfg_word[ORD_HI:ORD_LO]) == 2'b10)) |-> !mux_sel[0]);

    // R9: restart request lands on the order's first entry
    p_restart_r9: assert property (@(posedge clk) disable iff (rst)
        (sel_valid && $past(cfg_word[MODE_BIT]) && $past(cfg_word[RST_BIT]))
        |-> (mux_sel == (($past(cfg_word[ORD_HI:ORD_LO]) == 2'b11) ? CH_W'(NUM_CH - 1) :
                         ($past(cfg_word[ORD_HI:ORD_LO]) == 2'b01) ? CH_W'(1) : CH_W'(0))));

endmodule

bind adc_scan_seq adc_scan_seq_chk #(
    .NUM_CH  (NUM_CH),
    .CYC_LEN (CYC_LEN),
    .CFG_W   (CFG_W)
) u_chk (.*);

// File: tb/test_adc_scan_seq.sv
`timescale 1ns/1ps
module test_adc_scan_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cfg_word = '0;
    logic [2:0]  mux_sel;
    logic        sel_valid;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    adc_scan_seq i_adc_scan_seq (
        .clk       (clk),
        .rst       (rst),
        .cfg_word  (cfg_word),
        .mux_sel   (mux_sel),
        .sel_valid (sel_valid)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    int seq_tab[4][$];
    int m_cnt = 0, m_idx = 0, m_ord = 0, m_sel = 0;
    bit m_scan = 0, m_valid = 0;

    initial begin
        for (int k = 0; k < 8; k++) seq_tab[0].push_back(k);
        for (int k = 1; k < 8; k += 2) seq_tab[1].push_back(k);
        for (int k = 0; k < 8; k += 2) seq_tab[2].push_back(k);
        for (int k = 7; k >= 0; k--) seq_tab[3].push_back(k);
    end

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_scan = 0; m_idx = 0; m_ord = 0; m_sel = 0; m_valid = 0;
        end else begin
            m_valid = 0;
            if (m_cnt == 15) begin
                m_valid = 1;
                if (!cfg_word[10]) begin
                    m_scan = 0;
                    m_idx = 0;
                    m_sel = int'(cfg_word[9:7]);
                end else begin
                    int o;
                    o = int'(cfg_word[9:8]);
                    if (!m_scan || o != m_ord || cfg_word[7]) m_idx = 0;
                    else m_idx = (m_idx + 1) % seq_tab[m_ord].size();
                    m_ord = o;
                    m_scan = 1;
                    m_sel = seq_tab[o][m_idx];
                end
            end
            m_cnt = (m_cnt + 1) % 16;
        end
    end

    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk("R12 model mux_sel", int'(mux_sel), m_sel);
            chk("R2 model sel_valid", int'(sel_valid), int'(m_valid));
        end
    end

    function automatic logic [15:0] w_man(input int ch, input logic [15:0] noise);
        return (16'(ch) << 7) | (noise & 16'hF87F);
    endfunction

    function automatic logic [15:0] w_scan(input int ord, input int rq, input logic [15:0] noise);
        return 16'h0400 | (16'(ord) << 8) | (16'(rq) << 7) | (noise & 16'hF87F);
    endfunction

    int exp_q[$];

    // Apply one word for exp_q.size() cycles and compare each strobed select
    task automatic run(input logic [15:0] w, input string tag);
        int n;
        n = exp_q.size();
        cfg_word = w;
        for (int i = 0; i < n; i++) begin
            int gap;
            gap = 0;
            do begin
                @(negedge clk);
                gap++;
            end while (!sel_valid && gap < 40);
            chk("R2 strobe spacing", gap, 16);
            chk(tag, int'(mux_sel), exp_q[i]);
        end
    endtask

    initial begin
        rst = 1'b1;
        cfg_word = 16'hFFFF;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset mux_sel", int'(mux_sel), 0);
        chk("R1 reset sel_valid", int'(sel_valid), 0);
        @(negedge clk);
        rst = 1'b0;
        cfg_word = '0;
        @(posedge clk);
        #1;
        chk("R1 after reset mux_sel", int'(mux_sel), 0);
        chk("R1 after reset sel_valid", int'(sel_valid), 0);
        @(negedge clk);
        // realign: run() counts from this negedge; one edge already passed
        exp_q = '{5};
        cfg_word = w_man(5, 16'hFFFF);
        begin
            int gap;
            gap = 1;
            do begin
                @(negedge clk);
                gap++;
            end while (!sel_valid && gap < 40);
            chk("R2 first strobe", gap, 16);
            chk("R3 manual 5", int'(mux_sel), 5);
        end
        exp_q = '{2};          run(w_man(2, 16'h0000), "R3 manual 2");
        exp_q = '{0};          run(w_man(0, 16'hF87F), "R3 manual 0 noise");
        exp_q = '{0,1,2,3,4,5,6,7,0,1};
        run(w_scan(0, 0, 16'h0000), "R4 R8 R11 ascending");
        exp_q = '{1,3,5,7,1,3}; run(w_scan(1, 0, 16'hA85A), "R5 R8 R10 odd");
        exp_q = '{0,2,4,6,0};   run(w_scan(2, 0, 16'h0000), "R6 R8 R10 even");
        exp_q = '{7,6,5,4,3,2,1,0,7,6,5};
        run(w_scan(3, 0, 16'h5025), "R7 R8 R10 descending");
        exp_q = '{7};          run(w_scan(3, 1, 16'h0000), "R9 restart desc");
        exp_q = '{6};          run(w_scan(3, 0, 16'h0000), "R9 advance after restart");
        exp_q = '{0,0,0};      run(w_scan(0, 1, 16'h0000), "R9 held restart asc");
        exp_q = '{1,2};        run(w_scan(0, 0, 16'h0000), "R9 bit7 clear advances");
        exp_q = '{1};          run(w_scan(1, 1, 16'h0000), "R9 restart odd");
        exp_q = '{7};          run(w_man(7, 16'h0000), "R3 leave scan manual 7");
        exp_q = '{0};          run(w_scan(2, 0, 16'h0000), "R11 enter scan even");
        exp_q = '{2};          run(w_scan(2, 0, 16'h0000), "R6 even step");
        exp_q = '{7};          run(w_scan(3, 0, 16'h0000), "R10 switch to desc");
        repeat (5) @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #500000;
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule